// File: doc/BRIEF.md
# Producer-to-Consumer Write-Through Line Buffer

This block is a small private store that sits between one producing accelerator and one consuming accelerator. The producer hands over whole cache lines. Each line is kept on chip and is also sent to memory. When the consumer later asks for a line that is still held, the store answers it without touching memory. Data is exchanged in sub-frames of 32 lines, so a sub-frame is 2 KB with the default 64-byte lines. With these short reuse distances the consumer finds most of its data in the buffer.

The buffer is always write-through and has no dirty state. A line that was never written, or that a later write has displaced, is fetched again from memory by its own line address. The returned data goes back to the consumer and is not kept in the buffer. The storage is direct-mapped on the line address and holds 512 lines of 64 bytes (32 KB) by default. One memory request port with a valid/ready handshake carries both the write-through traffic and the read misses. Two counters give the number of read hits and read misses.

Top module: `pc_flow_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it: both counters read 0, `cons_rsp_valid` is 0, `cons_rd_ready` is 1, and `mem_req_valid` is 0 unless a producer write is offered.
- R2: A producer write is accepted only in a cycle where `mem_req_ready` is 1. In that cycle the memory port carries the same write: `mem_req_write`=1, with the same line address and data.
- R3: A consumer read is a hit when the line is held. In that case `cons_rsp_valid` is 1 in the next cycle with the held data, no memory read is issued, and `hit_count` goes up by one.
- R4: A consumer read is a miss when the line is not held. In the next cycle a memory read (`mem_req_write`=0) is issued with the same line address. `cons_rd_ready` stays 0 until the data has been returned. `cons_rsp_valid` is 1 in the cycle after `mem_rsp_valid`, carrying `mem_rsp_data`, and `miss_count` goes up by one.
- R5: Returned miss data is not stored in the buffer, so a second read of the same line misses again.
- R6: Placement is direct-mapped: the index is the line address modulo LINES. A write always replaces the entry at its index, so a read of the line that was displaced misses and is served from memory.
- R7: While a miss read is waiting for `mem_req_ready`, it takes the memory port and `prod_wr_ready` is 0.
- R8: If a producer write and a consumer read are accepted in the same cycle for the same line, the read is a hit and returns the newly written data.
- R9: All 512 lines can be held at once. After a full sub-frame of 32 consecutive lines, or all 512 lines, has been written, each of those lines reads back as a hit.
- R10: Every accepted consumer read increments exactly one of `hit_count` and `miss_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_wr_valid | input | 1 | Producer offers a line write |
| prod_wr_ready | output | 1 | Producer write accepted this cycle |
| prod_wr_addr | input | ADDR_W | Line address of the write |
| prod_wr_data | input | LINE_BYTES*8 | Line data of the write |
| cons_rd_valid | input | 1 | Consumer offers a line read |
| cons_rd_ready | output | 1 | Consumer read accepted this cycle |
| cons_rd_addr | input | ADDR_W | Line address of the read |
| cons_rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| cons_rsp_data | output | LINE_BYTES*8 | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write-through, 0 for miss read |
| mem_req_addr | output | ADDR_W | Line address of the memory request |
| mem_req_data | output | LINE_BYTES*8 | Write data to memory |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | LINE_BYTES*8 | Memory read data |
| hit_count | output | CNT_W | Number of read hits |
| miss_count | output | CNT_W | Number of read misses |

## Verification
The assertions check on every cycle four things. Each accepted write appears unchanged on the memory port, and write acceptance depends on memory readiness. An accepted read either responds in the next cycle or issues a memory read for the same address. A pending miss read blocks both the producer and the consumer, memory data is returned one cycle after it arrives, and each accepted read moves the sum of the counters by exactly one. Whether a read should have hit at all depends on the history of writes, index collisions and same-cycle bypass. Only the bench's reference model can show that, together with the returned data values and the fact that miss data is not kept.

// File: rtl/fb_pkg.sv
package fb_pkg;

   typedef enum logic [1:0] {
      FB_IDLE      = 2'd0,
      FB_MISS_REQ  = 2'd1,
      FB_MISS_WAIT = 2'd2
   } fb_state_e;

   function automatic int unsigned fb_log2(input int unsigned value);
      int unsigned res;
      res = 0;
      while ((32'd1 << res) < value) res++;
      return res;
   endfunction

endpackage

// File: rtl/fb_store.sv
module fb_store #(
   parameter int unsigned LINES  = 512,
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 512,
   localparam int unsigned IDX_W = fb_pkg::fb_log2(LINES),
   localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);

   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_mem  [LINES];
   logic [DATA_W-1:0] data_mem [LINES];

   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] wr_tag;
   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;

   assign wr_idx = wr_addr[IDX_W-1:0];
   assign wr_tag = wr_addr[ADDR_W-1:IDX_W];
   assign lk_idx = lk_addr[IDX_W-1:0];
   assign lk_tag = lk_addr[ADDR_W-1:IDX_W];

   // per-entry valid flops, set by a write to that index
   for (genvar e = 0; e < LINES; e++) begin : g_valid
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            valid_q[e] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_mem[wr_idx]  <= wr_tag;
         data_mem[wr_idx] <= wr_data;
      end
   end

   logic same_line;
   logic held;

   assign same_line = wr_en && (wr_addr == lk_addr);
   assign held      = valid_q[lk_idx] && (tag_mem[lk_idx] == lk_tag);

   // a write landing in the same cycle on the same line is forwarded
   always_comb begin
      if (same_line) begin
         lk_hit  = 1'b1;
         lk_data = wr_data;
      end else begin
         lk_hit  = held;
         lk_data = data_mem[lk_idx];
      end
   end

endmodule

// File: rtl/fb_ctrl.sv
module fb_ctrl #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              wr_fire,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_ready,
   input  logic              lk_hit,
   input  logic [DATA_W-1:0] lk_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_data,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              hit_evt,
   output logic              miss_evt
);
   import fb_pkg::*;

   fb_state_e         state_q;
   logic [ADDR_W-1:0] miss_addr_q;
   logic              rd_fire;
   logic              miss_owns_port;

   assign miss_owns_port = (state_q == FB_MISS_REQ);
   assign rd_ready       = (state_q == FB_IDLE);
   assign rd_fire        = rd_valid && rd_ready;
   assign wr_ready       = mem_req_ready && !miss_owns_port;
   assign wr_fire        = wr_valid && wr_ready;
   assign hit_evt        = rd_fire && lk_hit;
   assign miss_evt       = rd_fire && !lk_hit;

   // shared memory port: a pending miss read wins over write-through
   assign mem_req_valid = miss_owns_port || wr_valid;
   assign mem_req_write = !miss_owns_port;
   assign mem_req_addr  = miss_owns_port ? miss_addr_q : wr_addr;
   assign mem_req_data  = wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= FB_IDLE;
         miss_addr_q <= '0;
         rsp_valid   <= 1'b0;
         rsp_data    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            FB_IDLE: begin
               if (hit_evt) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= lk_data;
               end else if (miss_evt) begin
                  miss_addr_q <= rd_addr;
                  state_q     <= FB_MISS_REQ;
               end
            end
            FB_MISS_REQ: begin
               if (mem_req_ready) state_q <= FB_MISS_WAIT;
            end
            FB_MISS_WAIT: begin
               if (mem_rsp_valid) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= mem_rsp_data;
                  state_q   <= FB_IDLE;
               end
            end
            default: state_q <= FB_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fb_counter.sv
module fb_counter #(
   parameter int unsigned W        = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] value
);

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   value <= '0;
         else if (inc && value != '1)  value <= value + W'(1);
      end
   end else begin : g_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   value <= '0;
         else if (inc) value <= value + W'(1);
      end
   end

endmodule

// File: rtl/pc_flow_buffer.sv
module pc_flow_buffer #(
   parameter int unsigned LINES          = 512,
   parameter int unsigned LINE_BYTES     = 64,
   parameter int unsigned ADDR_W         = 20,
   parameter int unsigned SUBFRAME_LINES = 32,
   parameter int unsigned CNT_W          = 32,
   parameter bit          SAT_COUNTERS   = 1'b1,
   localparam int unsigned DATA_W        = LINE_BYTES * 8,
   localparam int unsigned IDX_W         = fb_pkg::fb_log2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_wr_valid,
   output logic              prod_wr_ready,
   input  logic [ADDR_W-1:0] prod_wr_addr,
   input  logic [DATA_W-1:0] prod_wr_data,
   input  logic              cons_rd_valid,
   output logic              cons_rd_ready,
   input  logic [ADDR_W-1:0] cons_rd_addr,
   output logic              cons_rsp_valid,
   output logic [DATA_W-1:0] cons_rsp_data,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_data,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);

   if ((32'd1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (SUBFRAME_LINES == 0 || (LINES % SUBFRAME_LINES) != 0) begin : g_bad_sub
      $error("LINES must hold a whole number of sub-frames");
   end
   if (LINE_BYTES == 0 || CNT_W == 0) begin : g_bad_width
      $error("LINE_BYTES and CNT_W must be nonzero");
   end

   logic              wr_fire;
   logic              lk_hit;
   logic [DATA_W-1:0] lk_data;
   logic              hit_evt;
   logic              miss_evt;

   fb_store #(
      .LINES  (LINES),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_fire),
      .wr_addr (prod_wr_addr),
      .wr_data (prod_wr_data),
      .lk_addr (cons_rd_addr),
      .lk_hit  (lk_hit),
      .lk_data (lk_data)
   );

   fb_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) ctrl_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_valid      (prod_wr_valid),
      .wr_addr       (prod_wr_addr),
      .wr_data       (prod_wr_data),
      .wr_ready      (prod_wr_ready),
      .wr_fire       (wr_fire),
      .rd_valid      (cons_rd_valid),
      .rd_addr       (cons_rd_addr),
      .rd_ready      (cons_rd_ready),
      .lk_hit        (lk_hit),
      .lk_data       (lk_data),
      .rsp_valid     (cons_rsp_valid),
      .rsp_data      (cons_rsp_data),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_data  (mem_req_data),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .hit_evt       (hit_evt),
      .miss_evt      (miss_evt)
   );

   fb_counter #(.W(CNT_W), .SATURATE(SAT_COUNTERS)) hit_cnt_i (
      .clk (clk), .rst_n (rst_n), .inc (hit_evt), .value (hit_count)
   );

   fb_counter #(.W(CNT_W), .SATURATE(SAT_COUNTERS)) miss_cnt_i (
      .clk (clk), .rst_n (rst_n), .inc (miss_evt), .value (miss_count)
   );

endmodule

// File: rtl/pc_flow_buffer_chk.sv
module pc_flow_buffer_chk #(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned DATA_W = 512,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prod_wr_valid,
   input logic              prod_wr_ready,
   input logic [ADDR_W-1:0] prod_wr_addr,
   input logic [DATA_W-1:0] prod_wr_data,
   input logic              cons_rd_valid,
   input logic              cons_rd_ready,
   input logic [ADDR_W-1:0] cons_rd_addr,
   input logic              cons_rsp_valid,
   input logic [DATA_W-1:0] cons_rsp_data,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_data,
   input logic              mem_rsp_valid,
   input logic [DATA_W-1:0] mem_rsp_data,
   input logic [CNT_W-1:0]  hit_count,
   input logic [CNT_W-1:0]  miss_count
);

   logic             miss_rd_out;
   logic [CNT_W:0]   cnt_sum;
   logic             cnt_room;

   assign miss_rd_out = mem_req_valid && !mem_req_write;
   assign cnt_sum     = {1'b0, hit_count} + {1'b0, miss_count};
   assign cnt_room    = (hit_count != '1) && (miss_count != '1);

   AST_WT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_wr_valid && prod_wr_ready) |-> (mem_req_valid && mem_req_write &&
         mem_req_addr == prod_wr_addr && mem_req_data == prod_wr_data)); // R2

   AST_WR_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      prod_wr_ready |-> mem_req_ready); // R2

   AST_READ_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_rd_valid && cons_rd_ready) |=> (cons_rsp_valid ||
         (miss_rd_out && mem_req_addr == $past(cons_rd_addr)))); // R4

   AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      miss_rd_out |-> !cons_rd_ready); // R4

   AST_MISS_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      miss_rd_out |-> !prod_wr_ready); // R7

   AST_MISS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && !cons_rd_ready && !miss_rd_out) |=>
         (cons_rsp_valid && cons_rsp_data == $past(mem_rsp_data))); // R4

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_rd_valid && cons_rd_ready && cnt_room) |=>
         (cnt_sum == $past(cnt_sum) + 1'b1)); // R10

   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cons_rd_valid && cons_rd_ready) |=> $stable(cnt_sum)); // R10

endmodule

bind pc_flow_buffer pc_flow_buffer_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .prod_wr_valid  (prod_wr_valid),
   .prod_wr_ready  (prod_wr_ready),
   .prod_wr_addr   (prod_wr_addr),
   .prod_wr_data   (prod_wr_data),
   .cons_rd_valid  (cons_rd_valid),
   .cons_rd_ready  (cons_rd_ready),
   .cons_rd_addr   (cons_rd_addr),
   .cons_rsp_valid (cons_rsp_valid),
   .cons_rsp_data  (cons_rsp_data),
   .mem_req_valid  (mem_req_valid),
   .mem_req_ready  (mem_req_ready),
   .mem_req_write  (mem_req_write),
   .mem_req_addr   (mem_req_addr),
   .mem_req_data   (mem_req_data),
   .mem_rsp_valid  (mem_rsp_valid),
   .mem_rsp_data   (mem_rsp_data),
   .hit_count      (hit_count),
   .miss_count     (miss_count)
);

// File: tb/pc_flow_buffer_tb_top.sv
`timescale 1ns/1ps
module pc_flow_buffer_tb_top;

   localparam int ADDR_W = 20;
   localparam int DATA_W = 512;
   localparam int CNT_W  = 32;
   localparam int LINES  = 512;
   localparam int MEM_LAT = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prod_wr_valid = 1'b0;
   logic              prod_wr_ready;
   logic [ADDR_W-1:0] prod_wr_addr = '0;
   logic [DATA_W-1:0] prod_wr_data = '0;
   logic              cons_rd_valid = 1'b0;
   logic              cons_rd_ready;
   logic [ADDR_W-1:0] cons_rd_addr = '0;
   logic              cons_rsp_valid;
   logic [DATA_W-1:0] cons_rsp_data;
   logic              mem_req_valid;
   logic              mem_req_ready = 1'b1;
   logic              mem_req_write;
   logic [ADDR_W-1:0] mem_req_addr;
   logic [DATA_W-1:0] mem_req_data;
   logic              mem_rsp_valid = 1'b0;
   logic [DATA_W-1:0] mem_rsp_data = '0;
   logic [CNT_W-1:0]  hit_count;
   logic [CNT_W-1:0]  miss_count;

   always #2.5 clk = ~clk;

   pc_flow_buffer dut_i (.*);

   int checks = 0;
   int errors = 0;
   int seq = 0;

   // reference model state
   logic [DATA_W-1:0] mem_model [int];
   logic [ADDR_W-1:0] ref_addr  [int];
   logic [DATA_W-1:0] ref_data  [int];
   int                exp_hits = 0;
   int                exp_miss = 0;
   bit                exp_rsp = 0;
   bit                exp_rsp_miss = 0;
   logic [DATA_W-1:0] exp_data = '0;
   bit                busy = 0;
   bit                miss_req_pend = 0;
   logic [ADDR_W-1:0] miss_addr = '0;
   logic [DATA_W-1:0] miss_exp = '0;
   int                mem_cnt = 0;
   logic [DATA_W-1:0] mem_pend = '0;
   bit                done = 0;

   function automatic logic [DATA_W-1:0] line_data(input logic [ADDR_W-1:0] a, input int s);
      return {16{a[15:0], s[15:0]}};
   endfunction

   function automatic logic [DATA_W-1:0] mem_value(input logic [ADDR_W-1:0] a);
      if (mem_model.exists(int'(a))) return mem_model[int'(a)];
      return {16{32'hA5A5_0000 ^ 32'(a)}};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // reset-time checks (R1)
   always @(negedge clk) begin
      if (!rst_n) begin
         chk(hit_count == 0 && miss_count == 0, "R1", "counters in reset",
             DATA_W'({hit_count, miss_count}), '0);
         chk(cons_rsp_valid == 1'b0, "R1", "rsp_valid in reset", DATA_W'(cons_rsp_valid), '0);
         chk(cons_rd_ready == 1'b1, "R1", "rd_ready in reset", DATA_W'(cons_rd_ready), 1);
         chk(mem_req_valid == 1'b0, "R1", "mem_req_valid in reset", DATA_W'(mem_req_valid), '0);
      end
   end

   // cycle-by-cycle comparison against the behavioural model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(hit_count == CNT_W'(exp_hits), "R10", "hit_count",
             DATA_W'(hit_count), DATA_W'(exp_hits));
         chk(miss_count == CNT_W'(exp_miss), "R10", "miss_count",
             DATA_W'(miss_count), DATA_W'(exp_miss));
         chk(cons_rsp_valid == exp_rsp, "R3", "rsp_valid timing",
             DATA_W'(cons_rsp_valid), DATA_W'(exp_rsp));
         if (exp_rsp) begin
            chk(cons_rsp_data == exp_data, exp_rsp_miss ? "R4" : "R3", "rsp_data",
                cons_rsp_data, exp_data);
            if (exp_rsp_miss) busy = 0;
         end
         exp_rsp = 0;
         exp_rsp_miss = 0;
         chk(cons_rd_ready == !busy, "R4", "consumer stall", DATA_W'(cons_rd_ready),
             DATA_W'(!busy));
         if (mem_rsp_valid) begin
            chk(busy && !miss_req_pend, "R4", "memory reply only while waiting",
                DATA_W'(busy), 1);
            exp_rsp = 1;
            exp_rsp_miss = 1;
            exp_data = miss_exp;
         end
         chk(mem_req_valid == (miss_req_pend || prod_wr_valid), "R2", "mem_req_valid",
             DATA_W'(mem_req_valid), DATA_W'(miss_req_pend || prod_wr_valid));
         chk(prod_wr_ready == (mem_req_ready && !miss_req_pend), "R7", "prod_wr_ready",
             DATA_W'(prod_wr_ready), DATA_W'(mem_req_ready && !miss_req_pend));
         if (miss_req_pend) begin
            chk(!mem_req_write && mem_req_addr == miss_addr, "R4", "miss request address",
                DATA_W'(mem_req_addr), DATA_W'(miss_addr));
            if (mem_req_ready) begin
               miss_req_pend = 0;
               mem_pend = mem_value(miss_addr);
               mem_cnt = MEM_LAT;
            end
         end
         if (prod_wr_valid && prod_wr_ready) begin
            chk(mem_req_write && mem_req_addr == prod_wr_addr && mem_req_data == prod_wr_data,
                "R2", "write-through", mem_req_data, prod_wr_data);
            mem_model[int'(prod_wr_addr)] = prod_wr_data;
            ref_addr[int'(prod_wr_addr) % LINES] = prod_wr_addr;
            ref_data[int'(prod_wr_addr) % LINES] = prod_wr_data;
         end
         if (cons_rd_valid && cons_rd_ready) begin
            if (ref_addr.exists(int'(cons_rd_addr) % LINES) &&
                ref_addr[int'(cons_rd_addr) % LINES] == cons_rd_addr) begin
               exp_hits++;
               exp_rsp = 1;
               exp_data = ref_data[int'(cons_rd_addr) % LINES];
            end else begin
               exp_miss++;
               busy = 1;
               miss_req_pend = 1;
               miss_addr = cons_rd_addr;
               miss_exp = mem_value(cons_rd_addr);
            end
         end
      end
   end

   // memory responder
   always @(posedge clk) begin
      #1;
      mem_rsp_valid = 1'b0;
      if (mem_cnt > 0) begin
         mem_cnt = mem_cnt - 1;
         if (mem_cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data = mem_pend;
         end
      end
   end

   task automatic do_wr(input logic [ADDR_W-1:0] a);
      seq++;
      prod_wr_addr = a;
      prod_wr_data = line_data(a, seq);
      prod_wr_valid = 1'b1;
      @(negedge clk);
      while (!prod_wr_ready) @(negedge clk);
      @(posedge clk); #1;
      prod_wr_valid = 1'b0;
   endtask

   task automatic do_rd(input logic [ADDR_W-1:0] a);
      cons_rd_addr = a;
      cons_rd_valid = 1'b1;
      @(negedge clk);
      while (!cons_rd_ready) @(negedge clk);
      @(posedge clk); #1;
      cons_rd_valid = 1'b0;
   endtask

   task automatic do_wr_rd(input logic [ADDR_W-1:0] a);
      seq++;
      prod_wr_addr = a;
      prod_wr_data = line_data(a, seq);
      cons_rd_addr = a;
      prod_wr_valid = 1'b1;
      cons_rd_valid = 1'b1;
      @(negedge clk);
      while (!(prod_wr_ready && cons_rd_ready)) @(negedge clk);
      @(posedge clk); #1;
      prod_wr_valid = 1'b0;
      cons_rd_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (8) @(posedge clk);
      #1;
   endtask

   int hits_before;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R4: never-written line is fetched from memory
      do_rd(20'd5);
      settle();
      // R5: miss data is not kept, a second read misses again
      do_rd(20'd5);
      settle();
      chk(miss_count == 2, "R5", "second read still misses", DATA_W'(miss_count), 2);

      // R3 / R9: one sub-frame written, then read back
      for (int i = 0; i < 32; i++) do_wr(20'(100 + i));
      hits_before = exp_hits;
      for (int i = 0; i < 32; i++) do_rd(20'(100 + i));
      settle();
      chk(hit_count == CNT_W'(hits_before + 32), "R9", "sub-frame all hits",
          DATA_W'(hit_count), DATA_W'(hits_before + 32));

      // R6: index collision displaces the earlier line
      do_wr(20'd7);
      do_wr(20'(7 + LINES));
      do_rd(20'd7);
      settle();
      do_rd(20'(7 + LINES));
      settle();

      // R8: same-cycle write and read of one line
      do_wr(20'd40);
      do_wr_rd(20'd40);
      settle();

      // R7: miss read holds the port against a waiting producer write
      fork
         do_rd(20'd900);
         begin @(posedge clk); #1; do_wr(20'd300); end
         begin @(posedge clk); #1; mem_req_ready = 1'b0;
               repeat (4) @(posedge clk); #1 mem_req_ready = 1'b1; end
      join
      settle();

      // R2: memory back-pressure blocks write-through
      mem_req_ready = 1'b0;
      fork
         do_wr(20'd301);
         begin repeat (5) @(posedge clk); #1 mem_req_ready = 1'b1; end
      join
      settle();

      // R9: fill the whole store and read every line
      for (int i = 0; i < LINES; i++) do_wr(20'(4096 + i));
      hits_before = exp_hits;
      for (int i = 0; i < LINES; i++) do_rd(20'(4096 + i));
      settle();
      chk(hit_count == CNT_W'(hits_before + LINES), "R9", "full store all hits",
          DATA_W'(hit_count), DATA_W'(hits_before + LINES));

      // R4: an old line displaced by the fill goes back to memory
      do_rd(20'd100);
      settle();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule